// File: doc/BRIEF.md
# Standby Power-State Controller

This block decides when a small microcontroller stops its clocks and when it wakes up again. A sleep strobe from the CPU puts the chip into software standby, but only when three configuration bits agree. In standby the system clock is gated off and the oscillator is disabled. Register and RAM contents are assumed to be retained by the rest of the chip.

The block leaves standby by one of three paths. An interrupt wake (the non-maskable interrupt on a selectable edge, or one of the qualified maskable lines) restarts the oscillator. It then holds the clock off for a settling count chosen by a 3-bit field, and finally raises a one-cycle interrupt-exception request. A low reset pin brings the clock back at once and raises a reset-exception request when the pin returns high. A low hardware-standby pin overrides every other source and parks the block in a hardware-standby state. Leaving that state always goes through the reset sequence.

Top module: `stby_power_ctrl`

## Requirements
- R1: A sleep strobe in the active state moves `pwr_state` to 2 (software standby) at the next edge only when `cfg_stby_en`=1, `cfg_lowspd_on`=0 and `cfg_wdt_pss`=0; under any other combination the state stays 0.
- R2: In software standby (`pwr_state`=2) and hardware standby (3), `clk_stop`=1 and `osc_en`=0.
- R3: Only maskable lines 0, 1, 2, 6 and 7 (bits of `irq_pin`, active high) can wake the block; lines 3, 4 and 5 never do.
- R4: A wake-capable maskable line wakes the block only while its bit in `irq_en` is 1 and `cpu_mask` is 0.
- R5: An interrupt wake moves the state to 1 (settling) at the next edge, with `osc_en`=1 and `clk_stop`=1. The state stays 1 for exactly the settling length and then returns to 0. `wake_irq` is high for that first active cycle only.
- R6: The settling length for `cfg_sts` codes 0..7 is max(1, B >> SETTLE_SHIFT), where B is 8192, 16384, 32768, 65536, 131072, 262144, 2048 and 16 respectively.
- R7: Further wake events during settling do not restart or extend the settling count.
- R8: A low `res_n_pin` during standby or settling moves the state to 0 at the next edge, with the clock running at once (`clk_stop`=0, `osc_en`=1). `reset_exc` is high for one cycle after the edge at which `res_n_pin` is first seen high again.
- R9: A low `hstby_n_pin` during standby or settling moves the state to 3 at the next edge, even when an interrupt or reset wake is present in the same cycle.
- R10: From hardware standby, `hstby_n_pin` going high moves the state to 0 and starts the reset sequence. `reset_exc` pulses one cycle later if `res_n_pin` is high.
- R11: `cfg_nmi_rise`=1 makes a rising edge of `nmi_pin` the wake event and `cfg_nmi_rise`=0 a falling edge; the opposite edge does not wake.
- R12: `pwr_state` encodes 0 = active, 1 = settling, 2 = software standby, 3 = hardware standby. After reset it is 0 with `clk_stop`=0, `osc_en`=1 and both requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_req | input | 1 | One-cycle strobe from the CPU sleep instruction |
| cfg_stby_en | input | 1 | Standby enable configuration bit |
| cfg_lowspd_on | input | 1 | Low-speed mode select; must be 0 to enter standby |
| cfg_wdt_pss | input | 1 | Watchdog prescaler select; must be 0 to enter standby |
| cfg_nmi_rise | input | 1 | NMI wake edge: 1 rising, 0 falling |
| cfg_sts | input | 3 | Settling length select code |
| irq_en | input | NUM_IRQ | Per-line maskable interrupt enable |
| cpu_mask | input | 1 | CPU interrupt mask; 1 blocks maskable wakes |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| irq_pin | input | NUM_IRQ | Maskable interrupt request lines, active high |
| res_n_pin | input | 1 | Reset pin, active low |
| hstby_n_pin | input | 1 | Hardware-standby pin, active low |
| clk_stop | output | 1 | System clock gate off |
| osc_en | output | 1 | Oscillator enable |
| wake_irq | output | 1 | One-cycle interrupt-exception request after settling |
| reset_exc | output | 1 | One-cycle reset-exception request |
| pwr_state | output | 2 | Current power state |

## Verification
The hardest situation to reach is a second wake event in the middle of a settling window. It needs the block already in standby, one wake consumed, and the count partly run down before a fresh edge arrives. The bench drops the NMI pin during settling, then raises it again together with an enabled maskable line a few cycles in. It does this for every settle code and counts the settling cycles against the arithmetic length. The settle field is scaled down by a parameter so that all eight codes, and every combination of line, enable and mask, can each be driven from standby within a short run.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SWSTBY = 2'd2,
        ST_HWSTBY = 2'd3
    } pwr_state_e;

    // Settling length for a select code, scaled down by 'shift', never below one cycle.
    function automatic int unsigned settle_len(input logic [2:0] code, input int unsigned shift);
        int unsigned base;
        case (code)
            3'd6:    base = 32'd1 << 11;
            3'd7:    base = 32'd1 << 4;
            default: base = 32'd1 << (13 + int'(code));
        endcase
        base = base >> shift;
        return (base == 0) ? 32'd1 : base;
    endfunction

endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
    parameter int          NUM_IRQ    = 8,
    parameter logic [7:0]  WAKE_LINES = 8'b1100_0111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_pin,
    input  logic               cfg_nmi_rise,
    input  logic [NUM_IRQ-1:0] irq_pin,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               cpu_mask,
    output logic               nmi_wake,
    output logic               irq_wake
);

    logic               nmi_prev_d, nmi_prev_q;
    logic [NUM_IRQ-1:0] line_ok;

    always_comb begin
        nmi_prev_d = nmi_pin;
        nmi_wake   = cfg_nmi_rise ? (nmi_pin & ~nmi_prev_q) : (~nmi_pin & nmi_prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi_prev_q <= 1'b0;
        else        nmi_prev_q <= nmi_prev_d;
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        if (g < 8 && WAKE_LINES[g]) begin : g_cap
            assign line_ok[g] = irq_pin[g] & irq_en[g];
        end else begin : g_nocap
            assign line_ok[g] = 1'b0;
        end
    end

    assign irq_wake = (|line_ok) & ~cpu_mask;

    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wake |-> (!cpu_mask && |(irq_pin & irq_en)));

    p_rise_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_wake && cfg_nmi_rise) |-> (nmi_pin && !nmi_prev_q));

endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt
    import stby_pkg::*;
#(
    parameter int unsigned SETTLE_SHIFT = 0,
    parameter int unsigned CNT_W        = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] code,
    input  logic       run,
    output logic       done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = CNT_W'(settle_len(code, SETTLE_SHIFT) - 1);
        else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
        done = run && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/stby_power_ctrl.sv
module stby_power_ctrl
    import stby_pkg::*;
#(
    parameter int          NUM_IRQ      = 8,
    parameter logic [7:0]  WAKE_LINES   = 8'b1100_0111,
    parameter int unsigned SETTLE_SHIFT = 0,
    parameter int unsigned CNT_W        = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               cfg_stby_en,
    input  logic               cfg_lowspd_on,
    input  logic               cfg_wdt_pss,
    input  logic               cfg_nmi_rise,
    input  logic [2:0]         cfg_sts,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               cpu_mask,
    input  logic               nmi_pin,
    input  logic [NUM_IRQ-1:0] irq_pin,
    input  logic               res_n_pin,
    input  logic               hstby_n_pin,
    output logic               clk_stop,
    output logic               osc_en,
    output logic               wake_irq,
    output logic               reset_exc,
    output logic [1:0]         pwr_state
);

    typedef struct packed {
        pwr_state_e st;
        logic       rst_hold;
        logic       wake_irq;
        logic       reset_exc;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  nmi_wake, irq_wake, settle_done, cnt_load, enter_ok, in_stby;

    stby_wake_qual #(.NUM_IRQ(NUM_IRQ), .WAKE_LINES(WAKE_LINES)) u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .nmi_pin      (nmi_pin),
        .cfg_nmi_rise (cfg_nmi_rise),
        .irq_pin      (irq_pin),
        .irq_en       (irq_en),
        .cpu_mask     (cpu_mask),
        .nmi_wake     (nmi_wake),
        .irq_wake     (irq_wake)
    );

    stby_settle_cnt #(.SETTLE_SHIFT(SETTLE_SHIFT), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .code  (cfg_sts),
        .run   (r_q.st == ST_SETTLE),
        .done  (settle_done)
    );

    assign enter_ok = cfg_stby_en & ~cfg_lowspd_on & ~cfg_wdt_pss;
    assign in_stby  = (r_q.st == ST_SWSTBY) || (r_q.st == ST_SETTLE);

    always_comb begin
        r_d           = r_q;
        r_d.wake_irq  = 1'b0;
        r_d.reset_exc = 1'b0;
        cnt_load      = 1'b0;
        case (r_q.st)
            ST_ACTIVE: begin
                if (r_q.rst_hold) begin
                    if (res_n_pin) begin
                        r_d.rst_hold  = 1'b0;
                        r_d.reset_exc = 1'b1;
                    end
                end else if (sleep_req && enter_ok) begin
                    r_d.st = ST_SWSTBY;
                end
            end
            ST_SWSTBY: begin
                if (!hstby_n_pin) begin
                    r_d.st = ST_HWSTBY;
                end else if (!res_n_pin) begin
                    r_d.st       = ST_ACTIVE;
                    r_d.rst_hold = 1'b1;
                end else if (nmi_wake || irq_wake) begin
                    r_d.st   = ST_SETTLE;
                    cnt_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!hstby_n_pin) begin
                    r_d.st = ST_HWSTBY;
                end else if (!res_n_pin) begin
                    r_d.st       = ST_ACTIVE;
                    r_d.rst_hold = 1'b1;
                end else if (settle_done) begin
                    r_d.st       = ST_ACTIVE;
                    r_d.wake_irq = 1'b1;
                end
            end
            default: begin
                if (hstby_n_pin) begin
                    r_d.st       = ST_ACTIVE;
                    r_d.rst_hold = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_ACTIVE, rst_hold: 1'b0, wake_irq: 1'b0, reset_exc: 1'b0};
        else        r_q <= r_d;
    end

    assign pwr_state = r_q.st;
    assign clk_stop  = (r_q.st != ST_ACTIVE);
    assign osc_en    = (r_q.st == ST_ACTIVE) || (r_q.st == ST_SETTLE);
    assign wake_irq  = r_q.wake_irq;
    assign reset_exc = r_q.reset_exc;

    p_enter_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACTIVE && !(cfg_stby_en && !cfg_lowspd_on && !cfg_wdt_pss))
        |=> (r_q.st != ST_SWSTBY));

    p_clock_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2 || pwr_state == 2'd3) |-> (clk_stop && !osc_en));

    p_wake_after_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> ($past(r_q.st) == ST_SETTLE && r_q.st == ST_ACTIVE));

    p_settle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SETTLE && hstby_n_pin && res_n_pin && !settle_done)
        |=> (r_q.st == ST_SETTLE));

    p_reset_exc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_exc |-> ($past(res_n_pin) && r_q.st == ST_ACTIVE));

    p_hw_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stby && !hstby_n_pin) |=> (r_q.st == ST_HWSTBY));

    p_hw_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HWSTBY && hstby_n_pin) |=> (r_q.st == ST_ACTIVE && r_q.rst_hold));

    p_one_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_irq && reset_exc));

endmodule

// File: tb/sim_stby_power_ctrl.sv
module sim_stby_power_ctrl;

    localparam int SHIFT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       cfg_stby_en = 1'b1, cfg_lowspd_on = 1'b0, cfg_wdt_pss = 1'b0, cfg_nmi_rise = 1'b1;
    logic [2:0] cfg_sts = 3'd7;
    logic [7:0] irq_en = 8'h00;
    logic       cpu_mask = 1'b0;
    logic       nmi_pin = 1'b0;
    logic [7:0] irq_pin = 8'h00;
    logic       res_n_pin = 1'b1, hstby_n_pin = 1'b1;
    logic       clk_stop, osc_en, wake_irq, reset_exc;
    logic [1:0] pwr_state;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stby_power_ctrl #(.SETTLE_SHIFT(SHIFT)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .cfg_stby_en(cfg_stby_en), .cfg_lowspd_on(cfg_lowspd_on), .cfg_wdt_pss(cfg_wdt_pss),
        .cfg_nmi_rise(cfg_nmi_rise), .cfg_sts(cfg_sts), .irq_en(irq_en), .cpu_mask(cpu_mask),
        .nmi_pin(nmi_pin), .irq_pin(irq_pin), .res_n_pin(res_n_pin), .hstby_n_pin(hstby_n_pin),
        .clk_stop(clk_stop), .osc_en(osc_en), .wake_irq(wake_irq), .reset_exc(reset_exc),
        .pwr_state(pwr_state)
    );

    function automatic int exp_len(input int code);
        int b;
        if (code == 6)      b = 2048;
        else if (code == 7) b = 16;
        else                b = 8192 << code;
        b = b >> SHIFT;
        return (b < 1) ? 1 : b;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic enter_stby();
        cfg_stby_en = 1'b1; cfg_lowspd_on = 1'b0; cfg_wdt_pss = 1'b0;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R1 entry", int'(pwr_state), 2);
    endtask

    // Runs the settling window to its end and returns its length in cycles.
    task automatic run_settle(output int len);
        len = 0;
        while (pwr_state == 2'd1 && len < 20000) begin
            len++;
            step();
        end
    endtask

    task automatic nmi_rise_wake();
        cfg_nmi_rise = 1'b1;
        nmi_pin = 1'b1;
        step();
        nmi_pin = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        summary();
    end

    initial begin
        int len;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R12 reset state
        chk("R12 state", int'(pwr_state), 0);
        chk("R12 clk_stop", int'(clk_stop), 0);
        chk("R12 osc_en", int'(osc_en), 1);
        chk("R12 requests", int'(wake_irq | reset_exc), 0);

        // R1 entry condition sweep
        cfg_sts = 3'd7;
        for (int m = 0; m < 8; m++) begin
            cfg_stby_en = m[0]; cfg_lowspd_on = m[1]; cfg_wdt_pss = m[2];
            sleep_req = 1'b1;
            step();
            sleep_req = 1'b0;
            chk("R1 cond", int'(pwr_state), (m == 1) ? 2 : 0);
            if (pwr_state == 2'd2) begin
                chk("R2 clk_stop", int'(clk_stop), 1);
                chk("R2 osc_en", int'(osc_en), 0);
                nmi_rise_wake();
                run_settle(len);
            end
            step();
        end

        // R3 / R4 sweep over every line, enable and mask
        for (int ln = 0; ln < 8; ln++) begin
            for (int c = 0; c < 4; c++) begin
                bit can, en, msk, exp_wake;
                can = (ln <= 2) || (ln >= 6);
                en  = c[0]; msk = c[1];
                exp_wake = can && en && !msk;
                enter_stby();
                irq_en   = en ? (8'h01 << ln) : 8'h00;
                cpu_mask = msk;
                irq_pin  = 8'h01 << ln;
                step();
                chk(can ? "R4 gate" : "R3 line", int'(pwr_state), exp_wake ? 1 : 2);
                irq_pin = 8'h00; irq_en = 8'h00; cpu_mask = 1'b0;
                if (!exp_wake) begin
                    step();
                    chk("R3 no late wake", int'(pwr_state), 2);
                    nmi_rise_wake();
                end
                run_settle(len);
                step();
            end
        end

        // R5 / R6 / R7: every settle code, with re-wake mid-window
        for (int code = 0; code < 8; code++) begin
            cfg_sts = 3'(code);
            enter_stby();
            nmi_pin = 1'b1;
            step();
            chk("R5 settle state", int'(pwr_state), 1);
            chk("R5 osc_en", int'(osc_en), 1);
            chk("R5 clk_stop", int'(clk_stop), 1);
            nmi_pin = 1'b0;
            len = 0;
            while (pwr_state == 2'd1 && len < 20000) begin
                len++;
                if (len == 3) begin
                    nmi_pin = 1'b1; irq_pin = 8'h01; irq_en = 8'h01;
                end
                step();
            end
            nmi_pin = 1'b0; irq_pin = 8'h00; irq_en = 8'h00;
            chk(code == 1 ? "R7 no restart" : "R6 length", len, exp_len(code));
            chk("R5 back active", int'(pwr_state), 0);
            chk("R5 wake pulse", int'(wake_irq), 1);
            step();
            chk("R5 pulse ends", int'(wake_irq), 0);
            step();
        end

        // R11 falling-edge select and wrong edge ignored
        cfg_sts = 3'd7;
        nmi_pin = 1'b1; step(); step();
        cfg_nmi_rise = 1'b0;
        enter_stby();
        nmi_pin = 1'b0;
        step();
        chk("R11 falling wakes", int'(pwr_state), 1);
        run_settle(len);
        cfg_nmi_rise = 1'b1;
        nmi_pin = 1'b1; step(); step();
        enter_stby();
        nmi_pin = 1'b0;
        step(); step();
        chk("R11 wrong edge", int'(pwr_state), 2);
        nmi_rise_wake();
        chk("R11 rising wakes", int'(pwr_state), 1);
        run_settle(len);
        step();

        // R8 reset pin in standby
        enter_stby();
        res_n_pin = 1'b0;
        step();
        chk("R8 state", int'(pwr_state), 0);
        chk("R8 clk_stop", int'(clk_stop), 0);
        chk("R8 osc_en", int'(osc_en), 1);
        step();
        chk("R8 held", int'(reset_exc), 0);
        res_n_pin = 1'b1;
        step();
        chk("R8 reset_exc", int'(reset_exc), 1);
        step();
        chk("R8 pulse ends", int'(reset_exc), 0);

        // R8 reset pin during settling
        cfg_sts = 3'd0;
        enter_stby();
        nmi_rise_wake();
        chk("R8 settling", int'(pwr_state), 1);
        res_n_pin = 1'b0;
        step();
        chk("R8 from settle", int'(pwr_state), 0);
        res_n_pin = 1'b1;
        step();
        chk("R8 settle reset_exc", int'(reset_exc), 1);
        step();

        // R9 hardware standby wins over simultaneous wakes; R10 exit
        enter_stby();
        hstby_n_pin = 1'b0; res_n_pin = 1'b0; nmi_pin = 1'b1;
        irq_pin = 8'h01; irq_en = 8'h01;
        step();
        chk("R9 priority", int'(pwr_state), 3);
        chk("R2 hw clk_stop", int'(clk_stop), 1);
        chk("R2 hw osc_en", int'(osc_en), 0);
        res_n_pin = 1'b1; nmi_pin = 1'b0; irq_pin = 8'h00; irq_en = 8'h00;
        step();
        chk("R10 stays", int'(pwr_state), 3);
        hstby_n_pin = 1'b1;
        step();
        chk("R10 exit state", int'(pwr_state), 0);
        chk("R10 no early exc", int'(reset_exc), 0);
        step();
        chk("R10 reset_exc", int'(reset_exc), 1);

        // R9 from settling
        enter_stby();
        nmi_rise_wake();
        hstby_n_pin = 1'b0;
        step();
        chk("R9 from settle", int'(pwr_state), 3);
        hstby_n_pin = 1'b1;
        step(); step();
        chk("R10 second exit", int'(reset_exc), 1);
        step();

        summary();
    end

endmodule